// File: doc/BRIEF.md
# Shared-Memory Multi-Queue Word Manager

This block runs a set of 32 hardware word queues, each living as a circular buffer inside a single shared 32-bit SRAM. Software places each queue in the SRAM by writing a configuration word. That word holds a page base (one page is 16 words), a power-of-two buffer size and two log-coded watermark thresholds. Writing a queue's configuration word also empties that queue.

After configuration, software pushes a 32-bit entry by writing the queue's access address and pops the oldest entry by reading that same address. For every queue the block keeps a read pointer, a write pointer and an occupancy count. From these it derives four level flags (empty, nearly empty, nearly full, full) and two sticky error flags (underflow, overflow). The level flags are packed as 4 bits per queue into status words. The error flags are packed as 2 bits per queue and are cleared by writing 1 to them.

The bus uses a request/ready handshake. A transfer completes on the clock edge where `bus_req` and `bus_ready` are both high. The requester holds address, direction and write data until that edge.

Top module: `wq_manager`

## Requirements
- R1: Word address 0x40+q reads and writes the configuration word of queue q. Its fields are: bits 25:24 size code (0/1/2/3 give 16/32/64/128 words); bits 21:14 base page, where the buffer starts at SRAM word base*16; bits 28:26 nearly-empty watermark code; bits 31:29 nearly-full watermark code.
- R2: A write to word address q (0x00..0x1F) appends the write data to queue q. A read of that address returns the oldest entry and removes it, in first-in first-out order, and queues in disjoint regions do not disturb one another.
- R3: A queue holds exactly as many entries as its size code gives, and its pointers wrap within the buffer so that filling, draining and refilling preserve order. Empty and full are never reported together.
- R4: Word address 0x20+w returns level status for queues 8w..8w+7, with queue q in bits 4*(q%8)+3..4*(q%8). In each nibble, bit0 is empty, bit1 is nearly empty, bit2 is nearly full and bit3 is full.
- R5: Nearly empty is set when the count is at most the nearly-empty threshold. The watermark code maps 0,1,2,3,4,5,6,7 to 0,1,2,4,8,16,32,64 entries.
- R6: Nearly full is set when the free space (size minus count) is at most the nearly-full threshold, using the same code mapping.
- R7: A pop from an empty queue returns zero, leaves the queue unchanged and sets its underflow bit. Word address 0x24+v holds queues 16v..16v+15, with queue q's underflow at bit 2*(q%16) and its overflow at bit 2*(q%16)+1.
- R8: A push to a full queue discards the data and sets the queue's overflow bit.
- R9: Error bits stay set until a write to their error word carries a 1 in their position. Bits written as 0 are unchanged.
- R10: Writing a queue's configuration word empties that queue and leaves every other queue's contents intact.
- R11: After reset every level nibble reads 0x3, every error word reads 0 and every configuration word reads 0.
- R12: A push or pop that touches the SRAM raises `bus_ready` in the second cycle of the request. Every other access, including a rejected push or pop, raises `bus_ready` in the first cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Transfer request, held until ready |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 7 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while ready is high |
| bus_ready | output | 1 | Transfer completes at the next edge |

## Verification
Register reads, status reads and rejected pushes or pops answer in the first cycle of the request. Accepted pushes and pops answer one cycle later, after the SRAM access. The bench drives each request just after a falling edge and samples `bus_ready` and `bus_rdata` one time unit later in every low phase. It counts those low phases and compares the count with the expected latency, so both latency and data are checked at the exact cycle they become valid. Status words read after a completed push or pop already reflect that operation, because the pointers and count are updated on the edge that launches the SRAM access.

// File: rtl/wq_pkg.sv
package wq_pkg;

   typedef enum logic {ST_IDLE, ST_BUSY} wq_state_t;

   // configuration word layout, most significant field first
   typedef struct packed {
      logic [2:0] nf_code;
      logic [2:0] ne_code;
      logic [1:0] size_code;
      logic [1:0] rsv_hi;
      logic [7:0] base_page;
      logic [13:0] rsv_lo;
   } qcfg_t;

   localparam int PTR_W  = 7;
   localparam int CNT_W  = 8;
   localparam int PAGE_W = 12;

   function automatic logic [CNT_W-1:0] size_words(input logic [1:0] code);
      return 8'd16 << code;
   endfunction

   function automatic logic [CNT_W-1:0] wm_entries(input logic [2:0] code);
      return (code == 3'd0) ? 8'd0 : (8'd1 << (code - 3'd1));
   endfunction

endpackage

// File: rtl/wq_sram.sv
module wq_sram #(
   parameter int AW = 11,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          en,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (en) begin
         if (we) mem[addr] <= wdata;
         rdata <= mem[addr];
      end
   end
endmodule

// File: rtl/wq_queue_ctx.sv
module wq_queue_ctx
   import wq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [31:0]      cfg_wdata,
   input  logic             push,
   input  logic             pop,
   input  logic             ovf_set,
   input  logic             udf_set,
   input  logic [1:0]       err_clr,
   output qcfg_t            cfg_o,
   output logic [PTR_W-1:0] rd_ptr_o,
   output logic [PTR_W-1:0] wr_ptr_o,
   output logic [3:0]       lvl_o,
   output logic [1:0]       err_o
);
   qcfg_t            cfg_q;
   logic [PTR_W-1:0] rd_q, wr_q, wrap_mask;
   logic [CNT_W-1:0] cnt_q, size_n, free_n;
   logic [1:0]       err_q;

   assign size_n    = size_words(cfg_q.size_code);
   assign wrap_mask = size_n[PTR_W-1:0] - 7'd1;
   assign free_n    = size_n - cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= '0;
         err_q <= '0;
      end else begin
         if (cfg_we) begin
            cfg_q <= qcfg_t'(cfg_wdata);
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
         end else if (push) begin
            wr_q  <= (wr_q + 7'd1) & wrap_mask;
            cnt_q <= cnt_q + 8'd1;
         end else if (pop) begin
            rd_q  <= (rd_q + 7'd1) & wrap_mask;
            cnt_q <= cnt_q - 8'd1;
         end
         err_q <= (err_q & ~err_clr) | {ovf_set, udf_set};
      end
   end

   assign cfg_o    = cfg_q;
   assign rd_ptr_o = rd_q;
   assign wr_ptr_o = wr_q;
   assign err_o    = err_q;
   assign lvl_o    = {cnt_q == size_n,
                      free_n <= wm_entries(cfg_q.nf_code),
                      cnt_q <= wm_entries(cfg_q.ne_code),
                      cnt_q == 8'd0};
endmodule

// File: rtl/wq_manager.sv
module wq_manager
   import wq_pkg::*;
#(
   parameter int NQ      = 32,
   parameter int SRAM_AW = 11,
   localparam int AW     = $clog2(3 * NQ)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_req,
   input  logic          bus_we,
   input  logic [AW-1:0] bus_addr,
   input  logic [31:0]   bus_wdata,
   output logic [31:0]   bus_rdata,
   output logic          bus_ready
);
   localparam int QW       = $clog2(NQ);
   localparam int NLVL     = NQ / 8;
   localparam int NERR     = NQ / 16;
   localparam int LVL_BASE = NQ;
   localparam int ERR_BASE = NQ + NLVL;
   localparam int CFG_BASE = 2 * NQ;

   if (NQ < 16 || (NQ & (NQ - 1)) != 0) begin : g_bad_nq
      $error("NQ must be a power of two of at least 16");
   end
   if (SRAM_AW < 8 || SRAM_AW > PAGE_W) begin : g_bad_aw
      $error("SRAM_AW must lie between 8 and 12");
   end

   wq_state_t        st_q;
   logic             is_pop_q;
   int unsigned      ai;
   logic             acc_hit, lvl_hit, err_hit, cfg_hit, idle_req, reg_wr;
   logic             push_ok, push_rej, pop_ok, pop_rej;
   logic [QW-1:0]    qsel;
   int               lvl_idx, err_idx;
   qcfg_t            cfg_a [NQ];
   logic [PTR_W-1:0] rd_a  [NQ];
   logic [PTR_W-1:0] wr_a  [NQ];
   logic [3:0]       lvl_a [NQ];
   logic [4*NQ-1:0]  lvl_flat;
   logic [2*NQ-1:0]  err_flat;
   logic [PAGE_W-1:0] word_addr;
   logic [31:0]      sram_rdata;

   assign ai      = {{(32-AW){1'b0}}, bus_addr};
   assign qsel    = bus_addr[QW-1:0];
   assign acc_hit = ai < NQ;
   assign lvl_hit = ai >= LVL_BASE && ai < ERR_BASE;
   assign err_hit = ai >= ERR_BASE && ai < ERR_BASE + NERR;
   assign cfg_hit = ai >= CFG_BASE && ai < CFG_BASE + NQ;
   assign lvl_idx = int'(ai) - LVL_BASE;
   assign err_idx = int'(ai) - ERR_BASE;

   assign idle_req = bus_req && st_q == ST_IDLE;
   assign push_ok  = idle_req && acc_hit && bus_we && !lvl_a[qsel][3];
   assign push_rej = idle_req && acc_hit && bus_we && lvl_a[qsel][3];
   assign pop_ok   = idle_req && acc_hit && !bus_we && !lvl_a[qsel][0];
   assign pop_rej  = idle_req && acc_hit && !bus_we && lvl_a[qsel][0];
   assign reg_wr   = idle_req && bus_we && !acc_hit;

   for (genvar q = 0; q < NQ; q++) begin : g_q
      logic [1:0] clr;
      assign clr = (reg_wr && err_hit && err_idx == q / 16) ?
                   bus_wdata[2*(q%16) +: 2] : 2'b00;
      wq_queue_ctx i_ctx (
         .clk      (clk),
         .rst_n    (rst_n),
         .cfg_we   (reg_wr && cfg_hit && qsel == QW'(q)),
         .cfg_wdata(bus_wdata),
         .push     (push_ok && qsel == QW'(q)),
         .pop      (pop_ok && qsel == QW'(q)),
         .ovf_set  (push_rej && qsel == QW'(q)),
         .udf_set  (pop_rej && qsel == QW'(q)),
         .err_clr  (clr),
         .cfg_o    (cfg_a[q]),
         .rd_ptr_o (rd_a[q]),
         .wr_ptr_o (wr_a[q]),
         .lvl_o    (lvl_a[q]),
         .err_o    (err_flat[2*q +: 2])
      );
      assign lvl_flat[4*q +: 4] = lvl_a[q];
   end

   assign word_addr = {cfg_a[qsel].base_page, 4'h0} +
                      {5'b0, bus_we ? wr_a[qsel] : rd_a[qsel]};

   wq_sram #(.AW(SRAM_AW), .DW(32)) i_sram (
      .clk  (clk),
      .en   (push_ok || pop_ok),
      .we   (push_ok),
      .addr (word_addr[SRAM_AW-1:0]),
      .wdata(bus_wdata),
      .rdata(sram_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         is_pop_q <= 1'b0;
      end else if (st_q == ST_BUSY) begin
         st_q <= ST_IDLE;
      end else if (push_ok || pop_ok) begin
         st_q     <= ST_BUSY;
         is_pop_q <= pop_ok;
      end
   end

   assign bus_ready = (st_q == ST_BUSY) || (idle_req && !push_ok && !pop_ok);

   always_comb begin
      bus_rdata = '0;
      if (st_q == ST_BUSY) begin
         if (is_pop_q) bus_rdata = sram_rdata;
      end else if (idle_req && !bus_we) begin
         if (lvl_hit)      bus_rdata = lvl_flat[32*lvl_idx +: 32];
         else if (err_hit) bus_rdata = err_flat[32*err_idx +: 32];
         else if (cfg_hit) bus_rdata = cfg_a[qsel];
      end
   end
endmodule

// File: rtl/wq_checker.sv
module wq_checker #(
   parameter int NQ = 32,
   parameter int AW = 7
) (
   input logic            clk,
   input logic            rst_n,
   input logic            bus_req,
   input logic            bus_we,
   input logic [AW-1:0]   bus_addr,
   input logic [31:0]     bus_rdata,
   input logic            bus_ready,
   input logic            pop_rej,
   input logic            push_rej,
   input logic [4*NQ-1:0] lvl_flat,
   input logic [2*NQ-1:0] err_flat
);
   localparam int ERR_BASE = NQ + NQ / 8;

   // R12: a request left waiting is answered on the following cycle
   p_sram_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_ready |=> bus_ready);

   // R7: rejected pop answers at once with zero
   p_empty_pop_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pop_rej |-> bus_ready && bus_rdata == 32'h0);

   // R8: rejected push answers at once
   p_full_push_quick_r8: assert property (@(posedge clk) disable iff (!rst_n)
      push_rej |-> bus_ready);

   for (genvar q = 0; q < NQ; q++) begin : g_lvl
      // R3
      p_empty_full_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
         !(lvl_flat[4*q] && lvl_flat[4*q+3]));
      // R5
      p_empty_near_r5: assert property (@(posedge clk) disable iff (!rst_n)
         lvl_flat[4*q] |-> lvl_flat[4*q+1]);
      // R6
      p_full_near_r6: assert property (@(posedge clk) disable iff (!rst_n)
         lvl_flat[4*q+3] |-> lvl_flat[4*q+2]);
   end

   for (genvar b = 0; b < 2*NQ; b++) begin : g_err
      // R9: sticky until a write to its own error word
      p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
         err_flat[b] && !(bus_req && bus_we && bus_ready &&
                          int'(bus_addr) == ERR_BASE + b / 32)
         |=> err_flat[b]);
   end
endmodule

bind wq_manager wq_checker #(.NQ(NQ), .AW(AW)) i_wq_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_req  (bus_req),
   .bus_we   (bus_we),
   .bus_addr (bus_addr),
   .bus_rdata(bus_rdata),
   .bus_ready(bus_ready),
   .pop_rej  (pop_rej),
   .push_rej (push_rej),
   .lvl_flat (lvl_flat),
   .err_flat (err_flat)
);

// File: tb/test_wq_manager.sv
module test_wq_manager;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req = 1'b0;
   logic        bus_we = 1'b0;
   logic [6:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_ready;
   int          n_chk = 0;
   int          n_bad = 0;

   always #2.5 clk = ~clk;

   wq_manager i_wq_manager (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_ready(bus_ready)
   );

   // {we, addr, wdata, expected rdata, expected cycles}
   localparam int NV = 23;
   localparam logic [73:0] VEC [NV] = '{
      {1'b1, 7'h40, 32'h6801_0000, 32'h0000_0000, 2'd1},  // R1
      {1'b0, 7'h40, 32'h0,         32'h6801_0000, 2'd1},  // R1
      {1'b0, 7'h20, 32'h0,         32'h3333_3333, 2'd1},  // R4
      {1'b1, 7'h00, 32'h0000_00A1, 32'h0000_0000, 2'd2},  // R2 R12
      {1'b1, 7'h00, 32'h0000_00A2, 32'h0000_0000, 2'd2},
      {1'b0, 7'h20, 32'h0,         32'h3333_3332, 2'd1},  // R5
      {1'b1, 7'h00, 32'h0000_00A3, 32'h0000_0000, 2'd2},
      {1'b0, 7'h20, 32'h0,         32'h3333_3330, 2'd1},  // R5
      {1'b0, 7'h00, 32'h0,         32'h0000_00A1, 2'd2},  // R2
      {1'b0, 7'h00, 32'h0,         32'h0000_00A2, 2'd2},
      {1'b0, 7'h00, 32'h0,         32'h0000_00A3, 2'd2},
      {1'b0, 7'h20, 32'h0,         32'h3333_3333, 2'd1},
      {1'b0, 7'h00, 32'h0,         32'h0000_0000, 2'd1},  // R7
      {1'b0, 7'h24, 32'h0,         32'h0000_0001, 2'd1},  // R7
      {1'b1, 7'h24, 32'h0000_0002, 32'h0000_0000, 2'd1},  // R9
      {1'b0, 7'h24, 32'h0,         32'h0000_0001, 2'd1},  // R9
      {1'b1, 7'h24, 32'h0000_0001, 32'h0000_0000, 2'd1},
      {1'b0, 7'h24, 32'h0,         32'h0000_0000, 2'd1},  // R9
      {1'b1, 7'h49, 32'h2102_0000, 32'h0000_0000, 2'd1},
      {1'b1, 7'h09, 32'h0000_00B0, 32'h0000_0000, 2'd2},
      {1'b0, 7'h21, 32'h0,         32'h3333_3303, 2'd1},  // R4
      {1'b0, 7'h09, 32'h0,         32'h0000_00B0, 2'd2},  // R2
      {1'b0, 7'h21, 32'h0,         32'h3333_3333, 2'd1}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic xfer(input logic we, input logic [6:0] a, input logic [31:0] d,
                       output logic [31:0] rd, output int cyc);
      @(negedge clk);
      bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
      cyc = 0;
      #1;
      for (int k = 0; k < 8; k++) begin
         cyc++;
         if (bus_ready) break;
         @(negedge clk); #1;
      end
      rd = bus_rdata;
      @(posedge clk); #1;
      bus_req = 1'b0; bus_we = 1'b0;
   endtask

   task automatic op(input string req, input logic we, input logic [6:0] a,
                     input logic [31:0] d, input logic [31:0] exp, input int exp_cyc);
      logic [31:0] rd;
      int cyc;
      xfer(we, a, d, rd, cyc);
      if (!we) chk(req, rd, exp);
      chk({req, " latency"}, 32'(cyc), 32'(exp_cyc));
   endtask

   task automatic summary;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL R12 watchdog: got hung expected done");
      summary();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R11 reset state
      for (int w = 0; w < 4; w++) op("R11 level", 1'b0, 7'(8'h20 + w), 0, 32'h3333_3333, 1);
      op("R11 error0", 1'b0, 7'h24, 0, 0, 1);
      op("R11 error1", 1'b0, 7'h25, 0, 0, 1);
      op("R11 config", 1'b0, 7'h5F, 0, 0, 1);

      for (int v = 0; v < NV; v++)
         op($sformatf("R2 vector %0d", v), VEC[v][73], VEC[v][72:66],
            VEC[v][65:34], VEC[v][33:2], int'(VEC[v][1:0]));

      // R3 R6 R8: fill queue 31 (size 16, nearly full at 2 free)
      op("R1 cfg31", 1'b1, 7'h5F, 32'h4004_0000, 0, 1);
      for (int i = 0; i < 16; i++) begin
         op("R3 push31", 1'b1, 7'h1F, 32'h100 + i, 0, 2);
         if (i == 13) op("R6 nearly full", 1'b0, 7'h23, 0, 32'h4333_3333, 1);
      end
      op("R3 full", 1'b0, 7'h23, 0, 32'hC333_3333, 1);
      op("R8 reject push", 1'b1, 7'h1F, 32'hDEAD, 0, 1);
      op("R8 overflow bit", 1'b0, 7'h25, 0, 32'h8000_0000, 1);
      for (int i = 0; i < 16; i++) op("R8 order kept", 1'b0, 7'h1F, 0, 32'h100 + i, 2);
      op("R3 drained", 1'b0, 7'h23, 0, 32'h3333_3333, 1);
      for (int i = 0; i < 3; i++) op("R3 wrap push", 1'b1, 7'h1F, 32'h200 + i, 0, 2);
      for (int i = 0; i < 3; i++) op("R3 wrap pop", 1'b0, 7'h1F, 0, 32'h200 + i, 2);

      // R5 R6 R3: queue 5 at 128 words, nearly empty at 64
      op("R1 cfg5", 1'b1, 7'h45, 32'h1F08_0000, 0, 1);
      for (int i = 0; i < 128; i++) begin
         op("R3 push5", 1'b1, 7'h05, 32'h300 + i, 0, 2);
         if (i == 63) op("R5 at 64", 1'b0, 7'h20, 0, 32'h3323_3333, 1);
         if (i == 64) op("R5 at 65", 1'b0, 7'h20, 0, 32'h3303_3333, 1);
      end
      op("R6 full 128", 1'b0, 7'h20, 0, 32'h33C3_3333, 1);
      op("R8 reject 5", 1'b1, 7'h05, 32'hBAD, 0, 1);
      op("R8 ovf q5", 1'b0, 7'h24, 0, 32'h0000_0800, 1);
      for (int i = 0; i < 128; i++) op("R2 pop5", 1'b0, 7'h05, 0, 32'h300 + i, 2);
      op("R9 clear", 1'b1, 7'h24, 32'h0000_0800, 0, 1);
      op("R9 cleared", 1'b0, 7'h24, 0, 0, 1);

      // R10: reconfigure empties only its own queue
      op("R10 push31", 1'b1, 7'h1F, 32'hE1, 0, 2);
      op("R10 push31", 1'b1, 7'h1F, 32'hE2, 0, 2);
      op("R10 push0", 1'b1, 7'h00, 32'hF1, 0, 2);
      op("R10 recfg", 1'b1, 7'h5F, 32'h4004_0000, 0, 1);
      op("R10 level", 1'b0, 7'h23, 0, 32'h3333_3333, 1);
      op("R10 empty pop", 1'b0, 7'h1F, 0, 0, 1);
      op("R7 udf q31", 1'b0, 7'h25, 0, 32'hC000_0000, 1);
      op("R10 other queue", 1'b0, 7'h00, 0, 32'hF1, 2);
      op("R1 cfg readback", 1'b0, 7'h5F, 0, 32'h4004_0000, 1);

      summary();
   end
endmodule